// File: doc/BRIEF.md
# LCD Power-Up Command Sequencer

This block brings a 320x240 LCD controller with 16-bit colour out of power-up over a four-wire SPI link that has a separate data/command select line. On a start pulse it holds the panel's active-low reset pin low for one millisecond and then releases it for another millisecond. It then works through a constant configuration table stored as a series of records. Each record holds a parameter count, a command byte and that number of parameter bytes. When the table is done it waits five milliseconds and sends the display-on command. When display-on has left the shifter, it gives a one-cycle done pulse.

While idle, the block also takes sleep and wake requests. Each request is a single command with no parameters. The bytes go to an external SPI shifter one at a time over a valid/ready handshake, and each byte carries a data/command flag. The block drives chip select so that it frames each record.

Top module: `lcd_boot_seq`

## Requirements
- R1: After reset, busy_o, done_o and spi_valid_o are 0, and lcd_rst_n_o and cs_n_o are 1.
- R2: A start pulse in idle drives lcd_rst_n_o low for between CLK_KHZ and CLK_KHZ+2 cycles. It then holds lcd_rst_n_o high for at least CLK_KHZ cycles before chip select first falls.
- R3: The init stream sends the records in table order. For each record the command byte goes out with spi_dc_o=0, then exactly the stated number of parameter bytes with spi_dc_o=1. The count byte is never sent. The records include the following:
  - 0xCF is the first command, with parameters 00 83 30.
  - 0x36 takes 0x28.
  - 0x3A takes 0x55.
  - 0xE0 and 0xE1 each take 15 parameters.
  - The last record is 0x11, with no parameters.
- R4: cs_n_o is 0 whenever a byte is handed over. It rises once after each record's last byte, and only in a cycle in which spi_ready_i was 1, meaning the shifter is idle.
- R5: At least 5*CLK_KHZ cycles of chip-select-high separate the end of the 0x11 record from the display-on command 0x29. Display-on has no parameters.
- R6: done_o is a one-cycle pulse with busy_o low. It appears in the cycle after chip select is released at the end of display-on.
- R7: A power request in idle sends one command with spi_dc_o=0 and no parameters. The command is 0x10 when pwr_level_i=0 and 0x11 when pwr_level_i=1. It makes no reset pulse and no done pulse.
- R8: Start and power requests that arrive while busy_o is 1 are ignored and add no bytes to the stream.
- R9: When start_i and pwr_req_i are both high in the same idle cycle, start wins and the power request is dropped.
- R10: While spi_valid_o=1 and spi_ready_i=0, spi_valid_o, spi_byte_o and spi_dc_o hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that starts the power-up sequence |
| pwr_req_i | input | 1 | Pulse that requests a sleep or wake command |
| pwr_level_i | input | 1 | Requested power level: 0 sleep, 1 wake |
| spi_ready_i | input | 1 | The shifter can take a byte (and is idle) |
| busy_o | output | 1 | A sequence or command is in progress |
| done_o | output | 1 | One-cycle pulse when power-up completes |
| lcd_rst_n_o | output | 1 | Active-low reset pin of the panel |
| cs_n_o | output | 1 | Active-low chip select |
| spi_valid_o | output | 1 | A byte is offered to the shifter |
| spi_byte_o | output | 8 | Byte offered to the shifter |
| spi_dc_o | output | 1 | 0 for a command byte, 1 for a parameter byte |

## Verification
The idle state can see a start pulse and a power request in the same cycle. The bench provokes this by raising both inputs together on one clock. It judges the outcome by requiring that the very next byte handed to the shifter is the first table command rather than a sleep command, and that the whole init stream follows. The bench also fires both requests again in the middle of the table walk. A scoreboard flags any byte or record boundary beyond the expected stream, so the bench sees it if either request leaks in.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int NUM_RECORDS = 20;
    localparam int REC_W       = $clog2(NUM_RECORDS);
    localparam int MAX_PARAMS  = 15;
    localparam int CNT_W       = $clog2(MAX_PARAMS + 1);

    localparam logic [7:0] CMD_SLEEP_IN  = 8'h10;
    localparam logic [7:0] CMD_SLEEP_OUT = 8'h11;
    localparam logic [7:0] CMD_DISP_ON   = 8'h29;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_LO,
        S_RST_HI,
        S_LOAD,
        S_SEND,
        S_DRAIN,
        S_FIN,
        S_SETTLE
    } seq_state_e;

    typedef enum logic [1:0] {
        J_INIT,
        J_DISPON,
        J_POWER
    } job_e;

    typedef struct packed {
        seq_state_e        st;
        job_e              job;
        logic [REC_W-1:0]  rec;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  off;
        logic [7:0]        cmd;
        logic              done;
    } seq_regs_t;

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
    parameter int CLK_KHZ = 200000,
    parameter int MS_W    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [MS_W-1:0] ms_i,
    output logic            fire_o
);
    localparam int PW = $clog2(CLK_KHZ + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(CLK_KHZ - 1);

    typedef struct packed {
        logic            run;
        logic [PW-1:0]   pre;
        logic [MS_W-1:0] ms;
        logic            fire;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.fire = 1'b0;
        if (load_i) begin
            tmr_d.run = 1'b1;
            tmr_d.pre = PRE_TOP;
            tmr_d.ms  = ms_i;
        end else if (tmr_q.run) begin
            if (tmr_q.pre == '0) begin
                tmr_d.pre = PRE_TOP;
                if (tmr_q.ms <= MS_W'(1)) begin
                    tmr_d.run  = 1'b0;
                    tmr_d.fire = 1'b1;
                end else begin
                    tmr_d.ms = tmr_q.ms - MS_W'(1);
                end
            end else begin
                tmr_d.pre = tmr_q.pre - PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign fire_o = tmr_q.fire;

    // R5: an expiry is never followed directly by another without a reload
    a_r5_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o && !load_i |=> !fire_o);

endmodule

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
    import lcd_seq_pkg::*;
(
    input  logic [REC_W-1:0] rec_i,
    input  logic [CNT_W-1:0] pidx_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [7:0]       cmd_o,
    output logic [7:0]       par_o
);
    logic [119:0]     row;
    logic [CNT_W-1:0] sh;
    logic [119:0]     shifted;

    always_comb begin
        case (rec_i)
            5'd0:  begin cnt_o = 4'd3;  cmd_o = 8'hCF; row = 120'h008330; end
            5'd1:  begin cnt_o = 4'd4;  cmd_o = 8'hED; row = 120'h64031281; end
            5'd2:  begin cnt_o = 4'd3;  cmd_o = 8'hE8; row = 120'h850179; end
            5'd3:  begin cnt_o = 4'd5;  cmd_o = 8'hCB; row = 120'h392C003402; end
            5'd4:  begin cnt_o = 4'd1;  cmd_o = 8'hF7; row = 120'h20; end
            5'd5:  begin cnt_o = 4'd2;  cmd_o = 8'hEA; row = 120'h0000; end
            5'd6:  begin cnt_o = 4'd1;  cmd_o = 8'hC0; row = 120'h26; end
            5'd7:  begin cnt_o = 4'd1;  cmd_o = 8'hC1; row = 120'h11; end
            5'd8:  begin cnt_o = 4'd2;  cmd_o = 8'hC5; row = 120'h353E; end
            5'd9:  begin cnt_o = 4'd1;  cmd_o = 8'hC7; row = 120'hBE; end
            5'd10: begin cnt_o = 4'd1;  cmd_o = 8'h36; row = 120'h28; end
            5'd11: begin cnt_o = 4'd1;  cmd_o = 8'h37; row = 120'h00; end
            5'd12: begin cnt_o = 4'd1;  cmd_o = 8'h3A; row = 120'h55; end
            5'd13: begin cnt_o = 4'd2;  cmd_o = 8'hB1; row = 120'h001B; end
            5'd14: begin cnt_o = 4'd1;  cmd_o = 8'hF2; row = 120'h00; end
            5'd15: begin cnt_o = 4'd1;  cmd_o = 8'h26; row = 120'h01; end
            5'd16: begin cnt_o = 4'd15; cmd_o = 8'hE0;
                         row = 120'h0F312B0C0E084EF1370710030E0900; end
            5'd17: begin cnt_o = 4'd15; cmd_o = 8'hE1;
                         row = 120'h000E1403110731C148080F0C31360F; end
            5'd18: begin cnt_o = 4'd4;  cmd_o = 8'hB6; row = 120'h0A822700; end
            5'd19: begin cnt_o = 4'd0;  cmd_o = CMD_SLEEP_OUT; row = '0; end
            default: begin cnt_o = 4'd0; cmd_o = 8'h00; row = '0; end
        endcase
        // rows are right-aligned: parameter k sits (cnt-1-k) bytes from the bottom
        sh      = cnt_o - CNT_W'(1) - pidx_i;
        shifted = row >> {sh, 3'b000};
        par_o   = shifted[7:0];
    end

endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_KHZ   = 200000,
    parameter int RST_MS    = 1,
    parameter int SETTLE_MS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pwr_req_i,
    input  logic       pwr_level_i,
    input  logic       spi_ready_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       lcd_rst_n_o,
    output logic       cs_n_o,
    output logic       spi_valid_o,
    output logic [7:0] spi_byte_o,
    output logic       spi_dc_o
);
    localparam int MAX_MS = (RST_MS > SETTLE_MS) ? RST_MS : SETTLE_MS;
    localparam int MS_W   = $clog2(MAX_MS + 1);
    localparam logic [REC_W-1:0] LAST_REC = REC_W'(NUM_RECORDS - 1);

    seq_regs_t seq_d, seq_q;

    logic            tmr_load;
    logic [MS_W-1:0] tmr_ms;
    logic            tmr_fire;
    logic [CNT_W-1:0] rom_cnt;
    logic [7:0]       rom_cmd;
    logic [7:0]       rom_par;

    lcd_ms_timer #(
        .CLK_KHZ (CLK_KHZ),
        .MS_W    (MS_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .ms_i   (tmr_ms),
        .fire_o (tmr_fire)
    );

    lcd_init_rom u_rom (
        .rec_i  (seq_q.rec),
        .pidx_i (seq_q.off - CNT_W'(1)),
        .cnt_o  (rom_cnt),
        .cmd_o  (rom_cmd),
        .par_o  (rom_par)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_ms     = MS_W'(RST_MS);
        case (seq_q.st)
            S_IDLE: begin
                if (start_i) begin
                    seq_d.st  = S_RST_LO;
                    seq_d.job = J_INIT;
                    tmr_load  = 1'b1;
                end else if (pwr_req_i) begin
                    seq_d.cmd = pwr_level_i ? CMD_SLEEP_OUT : CMD_SLEEP_IN;
                    seq_d.cnt = '0;
                    seq_d.off = '0;
                    seq_d.job = J_POWER;
                    seq_d.st  = S_SEND;
                end
            end
            S_RST_LO: begin
                if (tmr_fire) begin
                    seq_d.st = S_RST_HI;
                    tmr_load = 1'b1;
                end
            end
            S_RST_HI: begin
                if (tmr_fire) begin
                    seq_d.st  = S_LOAD;
                    seq_d.rec = '0;
                end
            end
            S_LOAD: begin
                seq_d.cnt = rom_cnt;
                seq_d.cmd = rom_cmd;
                seq_d.off = '0;
                seq_d.st  = S_SEND;
            end
            S_SEND: begin
                if (spi_ready_i) begin
                    if (seq_q.off == seq_q.cnt) seq_d.st  = S_DRAIN;
                    else                        seq_d.off = seq_q.off + CNT_W'(1);
                end
            end
            S_DRAIN: begin
                if (spi_ready_i) seq_d.st = S_FIN;
            end
            S_FIN: begin
                case (seq_q.job)
                    J_INIT: begin
                        if (seq_q.rec == LAST_REC) begin
                            seq_d.st = S_SETTLE;
                            tmr_load = 1'b1;
                            tmr_ms   = MS_W'(SETTLE_MS);
                        end else begin
                            seq_d.rec = seq_q.rec + REC_W'(1);
                            seq_d.st  = S_LOAD;
                        end
                    end
                    J_DISPON: begin
                        seq_d.done = 1'b1;
                        seq_d.st   = S_IDLE;
                    end
                    default: seq_d.st = S_IDLE;
                endcase
            end
            S_SETTLE: begin
                if (tmr_fire) begin
                    seq_d.cmd = CMD_DISP_ON;
                    seq_d.cnt = '0;
                    seq_d.off = '0;
                    seq_d.job = J_DISPON;
                    seq_d.st  = S_SEND;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_IDLE, job: J_INIT, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy_o      = (seq_q.st != S_IDLE);
    assign done_o      = seq_q.done;
    assign lcd_rst_n_o = (seq_q.st != S_RST_LO);
    assign cs_n_o      = !((seq_q.st == S_SEND) || (seq_q.st == S_DRAIN));
    assign spi_valid_o = (seq_q.st == S_SEND);
    assign spi_dc_o    = (seq_q.off != '0);
    assign spi_byte_o  = (seq_q.off == '0) ? seq_q.cmd : rom_par;

    // R10: an offered byte is held until the shifter takes it
    a_r10_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        spi_valid_o && !spi_ready_i |=> spi_valid_o && $stable(spi_byte_o) && $stable(spi_dc_o));

    // R4: chip select is only released once the shifter reports idle
    a_r4_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> $past(spi_ready_i));

    // R2: the panel reset pulse only follows a start request
    a_r2_rst_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_rst_n_o) |-> $past(start_i));

    // R6: done lasts a single cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done is reported from idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/sim_lcd_boot_seq.sv
`timescale 1ns/1ps
module sim_lcd_boot_seq;
    localparam int C = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pwr_req_i = 1'b0;
    logic       pwr_level_i = 1'b0;
    logic       spi_ready = 1'b1;
    logic       busy_o, done_o, lcd_rst_n_o, cs_n_o, spi_valid_o, spi_dc_o;
    logic [7:0] spi_byte_o;

    always #2.5 clk = ~clk;

    lcd_boot_seq #(.CLK_KHZ(C), .RST_MS(1), .SETTLE_MS(5)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_req_i(pwr_req_i),
        .pwr_level_i(pwr_level_i), .spi_ready_i(spi_ready), .busy_o(busy_o),
        .done_o(done_o), .lcd_rst_n_o(lcd_rst_n_o), .cs_n_o(cs_n_o),
        .spi_valid_o(spi_valid_o), .spi_byte_o(spi_byte_o), .spi_dc_o(spi_dc_o)
    );

    typedef struct {
        bit         is_end;
        bit         dc;
        logic [7:0] b;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int shift_len = 3;
    int cyc = 0;
    int done_cnt = 0;
    int rst_falls = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic push_b(input bit dc, input logic [7:0] b, input string req);
        exp_t e;
        e.is_end = 0; e.dc = dc; e.b = b; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_end(input string req);
        exp_t e;
        e.is_end = 1; e.dc = 0; e.b = 8'h00; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_rec(input logic [7:0] cmd, input int n, input logic [119:0] row);
        push_b(0, cmd, "R3");
        for (int k = 0; k < n; k++) begin
            logic [119:0] s;
            s = row >> (8 * (n - 1 - k));
            push_b(1, s[7:0], "R3");
        end
        push_end("R4");
    endtask

    task automatic push_init();
        push_rec(8'hCF, 3, 120'h008330);
        push_rec(8'hED, 4, 120'h64031281);
        push_rec(8'hE8, 3, 120'h850179);
        push_rec(8'hCB, 5, 120'h392C003402);
        push_rec(8'hF7, 1, 120'h20);
        push_rec(8'hEA, 2, 120'h0000);
        push_rec(8'hC0, 1, 120'h26);
        push_rec(8'hC1, 1, 120'h11);
        push_rec(8'hC5, 2, 120'h353E);
        push_rec(8'hC7, 1, 120'hBE);
        push_rec(8'h36, 1, 120'h28);
        push_rec(8'h37, 1, 120'h00);
        push_rec(8'h3A, 1, 120'h55);
        push_rec(8'hB1, 2, 120'h001B);
        push_rec(8'hF2, 1, 120'h00);
        push_rec(8'h26, 1, 120'h01);
        push_rec(8'hE0, 15, 120'h0F312B0C0E084EF1370710030E0900);
        push_rec(8'hE1, 15, 120'h000E1403110731C148080F0C31360F);
        push_rec(8'hB6, 4, 120'h0A822700);
        push_rec(8'h11, 0, 120'h0);
        push_b(0, 8'h29, "R5");
        push_end("R6");
    endtask

    // shifter model and scoreboard monitor, both on the falling edge
    initial begin
        bit hs_pending = 0;
        int busy_cnt = 0;
        bit prev_valid = 0, prev_ready = 1, prev_csn = 1, prev_rstn = 1, prev_done = 0;
        bit prev_dc = 0;
        logic [7:0] prev_byte = 8'h00;
        int rst_fall_cyc = 0, rst_rise_cyc = 0, last_rise = 0;
        bit after_rst = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            cyc++;
            if (hs_pending) begin
                hs_pending = 0;
                if (shift_len > 0) begin
                    spi_ready = 1'b0;
                    busy_cnt = shift_len;
                end
            end else if (!spi_ready) begin
                busy_cnt--;
                if (busy_cnt == 0) spi_ready = 1'b1;
            end
            if (rst_n) begin
                if (prev_valid && !prev_ready)
                    chk(spi_valid_o && spi_byte_o == prev_byte && spi_dc_o == prev_dc,
                        "R10", "held byte", int'(spi_byte_o), int'(prev_byte));
                if (!lcd_rst_n_o && prev_rstn) begin
                    rst_fall_cyc = cyc;
                    rst_falls++;
                end
                if (lcd_rst_n_o && !prev_rstn) begin
                    chk(cyc - rst_fall_cyc >= C && cyc - rst_fall_cyc <= C + 2,
                        "R2", "reset low cycles", cyc - rst_fall_cyc, C + 1);
                    rst_rise_cyc = cyc;
                    after_rst = 1;
                end
                if (!cs_n_o && prev_csn) begin
                    if (after_rst) begin
                        chk(cyc - rst_rise_cyc >= C, "R2", "reset high before cs",
                            cyc - rst_rise_cyc, C);
                        after_rst = 0;
                    end
                    if (exp_q.size() > 0 && !exp_q[0].is_end && exp_q[0].b == 8'h29 && !exp_q[0].dc)
                        chk(cyc - last_rise >= 5 * C, "R5", "settle gap", cyc - last_rise, 5 * C);
                end
                if (cs_n_o && !prev_csn) begin
                    last_rise = cyc;
                    chk(prev_ready, "R4", "shifter idle at cs release", int'(prev_ready), 1);
                    if (exp_q.size() == 0) begin
                        chk(0, "R8", "unexpected record end", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(e.is_end, e.req, "record end", 1, int'(e.is_end));
                    end
                end
                if (spi_valid_o && spi_ready) begin
                    hs_pending = 1;
                    chk(!cs_n_o, "R4", "cs low at handover", int'(cs_n_o), 0);
                    if (exp_q.size() == 0) begin
                        chk(0, "R8", "unexpected byte", int'(spi_byte_o), 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(!e.is_end && e.dc == spi_dc_o && e.b == spi_byte_o, e.req,
                            "byte {dc,byte}", int'({spi_dc_o, spi_byte_o}),
                            e.is_end ? 32'hE0D : int'({e.dc, e.b}));
                    end
                end
                if (done_o) begin
                    done_cnt++;
                    chk(!busy_o, "R6", "busy at done", int'(busy_o), 0);
                    chk(cyc - last_rise == 1, "R6", "done delay", cyc - last_rise, 1);
                end
                if (prev_done)
                    chk(!done_o, "R6", "done width", int'(done_o), 0);
            end
            prev_valid = spi_valid_o;
            prev_ready = spi_ready;
            prev_csn   = cs_n_o;
            prev_rstn  = lcd_rst_n_o;
            prev_done  = done_o;
            prev_dc    = spi_dc_o;
            prev_byte  = spi_byte_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int d0, r0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !spi_valid_o && lcd_rst_n_o && cs_n_o,
            "R1", "outputs in reset", int'({busy_o, done_o, spi_valid_o, lcd_rst_n_o, cs_n_o}), 3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !done_o && !spi_valid_o && lcd_rst_n_o && cs_n_o,
            "R1", "outputs after reset", int'({busy_o, done_o, spi_valid_o, lcd_rst_n_o, cs_n_o}), 3);

        // full power-up, with requests injected while busy (R8)
        shift_len = 3;
        push_init();
        d0 = done_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3 * C + 20) @(negedge clk);
        chk(busy_o, "R8", "busy mid table", int'(busy_o), 1);
        start_i = 1'b1; pwr_req_i = 1'b1; pwr_level_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; pwr_req_i = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "stream complete", exp_q.size(), 0);
        chk(done_cnt == d0 + 1, "R6", "one done pulse", done_cnt - d0, 1);

        // sleep request, shifter always ready (R7)
        shift_len = 0;
        d0 = done_cnt; r0 = rst_falls;
        push_b(0, 8'h10, "R7");
        push_end("R7");
        pwr_level_i = 1'b0; pwr_req_i = 1'b1;
        @(negedge clk);
        pwr_req_i = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R7", "sleep stream", exp_q.size(), 0);
        chk(rst_falls == r0, "R7", "no reset pulse on sleep", rst_falls - r0, 0);
        chk(done_cnt == d0, "R7", "no done on sleep", done_cnt - d0, 0);

        // wake request, slow shifter (R7)
        shift_len = 5;
        push_b(0, 8'h11, "R7");
        push_end("R7");
        pwr_level_i = 1'b1; pwr_req_i = 1'b1;
        @(negedge clk);
        pwr_req_i = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0, "R7", "wake stream", exp_q.size(), 0);
        chk(rst_falls == r0, "R7", "no reset pulse on wake", rst_falls - r0, 0);
        chk(done_cnt == d0, "R7", "no done on wake", done_cnt - d0, 0);

        // start and power request in the same idle cycle (R9)
        shift_len = 1;
        push_init();
        d0 = done_cnt;
        start_i = 1'b1; pwr_req_i = 1'b1; pwr_level_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; pwr_req_i = 1'b0;
        chk(!lcd_rst_n_o, "R9", "start won: reset low", int'(lcd_rst_n_o), 0);
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "only init stream", exp_q.size(), 0);
        chk(!busy_o && cs_n_o && lcd_rst_n_o, "R9", "idle after power-up",
            int'({busy_o, cs_n_o, lcd_rst_n_o}), 3);

        finish_run();
    end

endmodule